// File: doc/BRIEF.md
# Stepped Stereo Digital Attenuator

This block scales a stereo stream of 16-bit two's-complement samples by a linear gain for each channel. The gain of a channel is held in an 8-bit counter; a gain of count/255 is applied, so a count of 255 passes the sample unchanged (0 dB) and a count of 0 silences it. Control writes load a target byte for the counters. They do not set the gain directly. On every sample strobe each counter moves one count toward its target and stops once it arrives. A gain change therefore ramps smoothly rather than jumping.

A control write carries a target byte, a one-bit channel select and a link flag. With the link flag low, only the selected channel's target changes. With it high, both targets take the byte and the select bit is ignored. A write during a ramp takes effect at once: the counter keeps its present value and heads for the new target from there. Both counter values are brought out so that a neighbouring mute detector can watch for a gain of zero.

Top module: `stereo_atten`

## Requirements
- R1: During and after synchronous active-low reset, both gain counts read 255, both output samples read 0, out_valid is low, and both targets are 255, so independent-mode operation at 0 dB is the default.
- R2: A write with cfg_link = 0 loads cfg_target into the left target when cfg_sel = 0, or into the right target when cfg_sel = 1, and leaves the other channel's target unchanged.
- R3: A write with cfg_link = 1 loads cfg_target into both targets, whatever the value of cfg_sel.
- R4: On each cycle with smp_valid high, each counter moves exactly one count toward its target, or holds if it already equals the target. On cycles without smp_valid the counters do not change.
- R5: On a cycle with smp_valid high, the design registers each output sample as the input sample times that channel's count before this strobe's step, divided by 255 and truncated toward zero. out_valid is high in the following cycle only.
- R6: With a count of 255 the output equals the input exactly, including -32768. With a count of 0 the output is 0.
- R7: A write that arrives during a ramp redirects the counter from its present value on the next strobe, without reloading or resetting it.
- R8: gain_left and gain_right always show the present left and right counter values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control write strobe, one cycle |
| cfg_target | input | 8 | Target count written |
| cfg_sel | input | 1 | Channel select: 0 left, 1 right |
| cfg_link | input | 1 | 1 loads both channel targets |
| smp_valid | input | 1 | Sample strobe |
| smp_left | input | 16 | Left input sample, two's complement |
| smp_right | input | 16 | Right input sample, two's complement |
| out_valid | output | 1 | Output samples updated |
| out_left | output | 16 | Scaled left sample |
| out_right | output | 16 | Scaled right sample |
| gain_left | output | 8 | Present left counter value |
| gain_right | output | 8 | Present right counter value |

## Verification
A write is registered at the clock edge where cfg_wr is high. The counters step at the edge where smp_valid is high, so the first strobe after a write already uses the new target, and the counts can be read one edge after that strobe. The scaled samples and out_valid appear one edge after their strobe and use the count from before that strobe's step. The bench therefore computes each expected pair from its model counts before it advances the model. It queues the pair and compares it when out_valid is seen. It reads the gain ports a short delay after every strobe edge, and across idle cycles. All inputs change and all outputs are read 1 ns after a rising edge.

// File: rtl/atten_pkg.sv
// Package: shared widths and channel indices for the stereo attenuator.
// Assumes two channels; widths may be changed consistently here.
package atten_pkg;
    localparam int SMP_W  = 16;           // sample width
    localparam int CNT_W  = 8;            // gain counter width
    localparam int NCH    = 2;            // number of channels
    localparam int CH_L   = 0;            // left channel index
    localparam int CH_R   = 1;            // right channel index

    typedef logic [CNT_W-1:0]        cnt_t;
    typedef logic signed [SMP_W-1:0] smp_t;
endpackage

// File: rtl/atten_target_regs.sv
// Module: holds the per-channel target counts and applies control writes.
// Assumes cfg_wr is a one-cycle strobe; link=1 writes all channels,
// link=0 writes only the channel picked by sel. Reset target is full scale.
module atten_target_regs #(
    parameter int CNT_W = 8,
    parameter int NCH   = 2,
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] target,
    input  logic [SEL_W-1:0] sel,
    input  logic             link,
    output logic [CNT_W-1:0] tgt [NCH]
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic hit;
        // Decode whether this write addresses this channel.
        always_comb hit = wr && (link || (sel == SEL_W'(ch)));

        // Target register: reset to full scale, load on addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n)   tgt[ch] <= FULL;
            else if (hit) tgt[ch] <= target;
        end

        // R2: a write that does not address this channel leaves it alone.
        a_r2_untouched: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && !link && sel != SEL_W'(ch)) |=> $stable(tgt[ch]));
        // R3: a linked write always reaches this channel.
        a_r3_linked: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && link) |=> (tgt[ch] == $past(target)));
    end
endmodule

// File: rtl/atten_ramp.sv
// Module: one channel's gain counter, stepping one count per strobe
// toward its target and holding when equal. Assumes the target may change
// on any cycle; the counter is never reloaded, only stepped.
module atten_ramp #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [CNT_W-1:0] target,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic up, down;
    // Direction decode against the present target.
    always_comb begin
        up   = step && (count < target);
        down = step && (count > target);
    end

    // Counter: full scale on reset, one step per strobe otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= FULL;
        else if (up)   count <= count + ONE;
        else if (down) count <= count - ONE;
    end

    // R4: no strobe, no movement.
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(count));
    // R4: any movement is by at most one count.
    a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (count == $past(count)) || (count == $past(count) + ONE)
                 || (count + ONE == $past(count)));
    // R4: a counter at its target stays there.
    a_r4_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
        (step && count == target) |=> $stable(count));
endmodule

// File: rtl/atten_scale.sv
// Module: one channel's gain stage. On each strobe it registers
// sample * count / (2**CNT_W - 1), truncated toward zero. Assumes the
// count is unsigned, so the result magnitude never exceeds the input.
module atten_scale #(
    parameter int SMP_W = 16,
    parameter int CNT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [SMP_W-1:0] sample,
    input  logic [CNT_W-1:0]        count,
    output logic signed [SMP_W-1:0] result
);
    localparam int PW = SMP_W + CNT_W + 1;
    localparam logic signed [PW-1:0] DIVISOR = PW'((1 << CNT_W) - 1);
    localparam logic [CNT_W-1:0]     FULL    = {CNT_W{1'b1}};

    logic signed [PW-1:0]    prod;
    logic signed [PW-1:0]    quot;
    logic signed [SMP_W-1:0] scaled;

    // Exact product and truncating divide by full scale.
    always_comb begin
        prod   = PW'(sample) * $signed({{(SMP_W){1'b0}}, count});
        quot   = prod / DIVISOR;
        scaled = SMP_W'(quot);
    end

    // Output register: cleared on reset, updated on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  result <= '0;
        else if (en) result <= scaled;
    end

    // R6: full scale passes the sample through.
    a_r6_unity: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count == FULL) |=> (result == $past(sample)));
    // R6: zero count gives silence.
    a_r6_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count == '0) |=> (result == '0));
    // R5: output holds between strobes.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(result));
endmodule

// File: rtl/stereo_atten.sv
// Module: top of the stepped stereo attenuator. Control writes set
// per-channel targets; each sample strobe scales both samples by the
// present counts and steps the counts toward their targets.
// Assumes smp_valid strobes are at least one cycle apart or continuous.
module stereo_atten
    import atten_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_target,
    input  logic             cfg_sel,
    input  logic             cfg_link,
    input  logic             smp_valid,
    input  logic [15:0]      smp_left,
    input  logic [15:0]      smp_right,
    output logic             out_valid,
    output logic [15:0]      out_left,
    output logic [15:0]      out_right,
    output logic [7:0]       gain_left,
    output logic [7:0]       gain_right
);
    cnt_t tgt   [NCH];
    cnt_t count [NCH];
    smp_t smp_in  [NCH];
    smp_t smp_out [NCH];

    // Gather per-channel inputs into arrays.
    always_comb begin
        smp_in[CH_L] = smp_t'(smp_left);
        smp_in[CH_R] = smp_t'(smp_right);
    end

    atten_target_regs #(.CNT_W(CNT_W), .NCH(NCH)) u_targets (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .target (cfg_target),
        .sel    (cfg_sel),
        .link   (cfg_link),
        .tgt    (tgt)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        atten_ramp #(.CNT_W(CNT_W)) u_ramp (
            .clk    (clk),
            .rst_n  (rst_n),
            .step   (smp_valid),
            .target (tgt[ch]),
            .count  (count[ch])
        );
        atten_scale #(.SMP_W(SMP_W), .CNT_W(CNT_W)) u_scale (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (smp_valid),
            .sample (smp_in[ch]),
            .count  (count[ch]),
            .result (smp_out[ch])
        );
    end

    // Valid flag: follows the sample strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= smp_valid;
    end

    // Drive output ports from the channel arrays.
    always_comb begin
        out_left   = smp_out[CH_L];
        out_right  = smp_out[CH_R];
        gain_left  = count[CH_L];
        gain_right = count[CH_R];
    end

    // R5: out_valid is a one-cycle echo of the strobe.
    a_r5_valid: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> out_valid);
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !out_valid);
    // R1: at reset both gains read full scale.
    a_r1_reset_gain: assert property (@(posedge clk)
        !rst_n |=> (gain_left == 8'hFF && gain_right == 8'hFF && !out_valid));
endmodule

// File: tb/stereo_atten_tb.sv
module stereo_atten_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_target = '0;
    logic        cfg_sel = 1'b0;
    logic        cfg_link = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_left = '0;
    logic [15:0] smp_right = '0;
    logic        out_valid;
    logic [15:0] out_left, out_right;
    logic [7:0]  gain_left, gain_right;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done = 0;

    int m_cnt [2];
    int m_tgt [2];
    int q_l [$];
    int q_r [$];

    always #2.5 clk = ~clk;

    stereo_atten u_dut (.*);

    function automatic int scale_ref(int s, int c);
        return (s * c) / 255;
    endfunction

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    // Control write; model updated to match requirement R2/R3.
    task automatic write_cfg(int t, bit sel, bit link);
        cfg_wr = 1; cfg_target = 8'(t); cfg_sel = sel; cfg_link = link;
        @(posedge clk); #1;
        cfg_wr = 0;
        if (link) begin m_tgt[0] = t; m_tgt[1] = t; end
        else m_tgt[sel] = t;
    endtask

    // Driver: one strobe, expected outputs pushed before the model steps.
    task automatic send(int l, int r);
        smp_left = 16'(l); smp_right = 16'(r); smp_valid = 1;
        q_l.push_back(scale_ref(l, m_cnt[0]));
        q_r.push_back(scale_ref(r, m_cnt[1]));
        for (int c = 0; c < 2; c++) begin
            if (m_cnt[c] < m_tgt[c]) m_cnt[c]++;
            else if (m_cnt[c] > m_tgt[c]) m_cnt[c]--;
        end
        @(posedge clk); #1;
        smp_valid = 0;
        check("R4/R8 gain_left", int'(gain_left), m_cnt[0]);
        check("R4/R8 gain_right", int'(gain_right), m_cnt[1]);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            check("R4 idle gain_left", int'(gain_left), m_cnt[0]);
            check("R4 idle gain_right", int'(gain_right), m_cnt[1]);
        end
    endtask

    function automatic int pat(int i);
        return ((i * 7919 + 1234) % 65536) - 32768;
    endfunction

    // Monitor: compare each output pair against the scoreboard (R5).
    always @(posedge clk) begin
        #1;
        if (rst_n && out_valid) begin
            if (q_l.size() == 0) check("R5 unexpected out_valid", 1, 0);
            else begin
                check("R5 out_left", int'($signed(out_left)), q_l.pop_front());
                check("R5 out_right", int'($signed(out_right)), q_r.pop_front());
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check("watchdog", 1, 0);
            finish_run();
        end
    end

    initial begin
        m_cnt[0] = 255; m_cnt[1] = 255; m_tgt[0] = 255; m_tgt[1] = 255;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 gain_left", int'(gain_left), 255);
        check("R1 gain_right", int'(gain_right), 255);
        check("R1 out_left", int'(out_left), 0);
        check("R1 out_valid", int'(out_valid), 0);
        rst_n = 1;
        @(posedge clk); #1;
        // R6 unity at full scale, including extremes
        send(-32768, 32767);
        send(1234, -5);
        idle(1);
        // R2 independent left write
        write_cfg(250, 0, 0);
        for (int i = 0; i < 8; i++) send(pat(i), pat(i + 40));
        // R2 independent right write; left already at target stays
        write_cfg(100, 1, 0);
        for (int i = 0; i < 20; i++) send(pat(i + 3), pat(i + 77));
        idle(3);
        // R3 linked write ignores select
        write_cfg(0, 1, 1);
        for (int i = 0; i < 30; i++) send(pat(i + 200), pat(i + 300));
        // R7 retarget mid-ramp both directions
        write_cfg(240, 0, 0);
        for (int i = 0; i < 10; i++) send(-32768, 32767);
        write_cfg(2, 0, 0);
        for (int i = 0; i < 12; i++) send(pat(i + 500), -32768);
        // R6 zero: drive right to 0 and hold
        for (int i = 0; i < 260; i++) send(pat(i + 900), pat(i + 1300));
        send(-32768, -32768);
        // back to full scale for R6 unity
        write_cfg(255, 0, 1);
        for (int i = 0; i < 260; i++) send(pat(i + 2000), pat(i + 2600));
        send(-32768, 32767);
        idle(2);
        check("R5 scoreboard drained", q_l.size(), 0);
        finish_run();
    end
endmodule